// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the combinational arithmetic and logic stage of a small 8-bit processor core. It takes two operands, an operation code and the current status byte. It returns the result, the next status byte, and a strobe that says whether the result should be written back to the destination register.

The status byte holds eight flags, from bit 7 down to bit 0:

- interrupt enable (I)
- transfer bit (T)
- half carry (H)
- sign (S)
- overflow (V)
- negative (N)
- zero (Z)
- carry (C)

Every operation updates only its own group of flags. All other flag bits pass through from `status_in` unchanged. Immediate forms of the instructions reuse the register opcodes, with the immediate value presented on `op_b`. Single-operand operations read only `op_a`.

Top module: `alu8_core`

## Requirements
- R1: Opcode values are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17, SWAP=18. For codes 19 to 31, `result_we` is 0 and `status_out` equals `status_in`.
- R2: ADD and ADC (ADC adds C) write `op_a+op_b(+C)`. They set C from the bit-7 carry, H from the bit-3 carry, and V on signed overflow; Z and N follow the result.
- R3: Bits 7 (I) and 6 (T) of `status_out` always equal those of `status_in`.
- R4: SUB, SBC, CP and CPC compute `op_a-op_b(-C for SBC/CPC)`. C is the bit-7 borrow, H is the bit-3 borrow, V is signed overflow, and N is result bit 7. CP and CPC drive `result_we` to 0; the other ops listed in R1 drive it to 1.
- R5: For SBC and CPC, Z is 1 only when the result is zero and the incoming Z is 1.
- R6: AND, OR and XOR write the bitwise result, clear V, update Z and N, and leave C and H unchanged.
- R7: COM writes `0xFF-op_a` and sets C=1, V=0. NEG writes `0x00-op_a` and sets C when the result is nonzero, V when the result is 0x80, and H when the low nibble of `op_a` is nonzero.
- R8: INC and DEC write `op_a±1`. V is set for INC of 0x7F and for DEC of 0x80. C and H are unchanged.
- R9: Each shift and rotate sets C to the bit shifted out and V to N XOR C, and leaves H unchanged:
  - LSL shifts left and fills bit 0 with 0.
  - LSR shifts right and fills bit 7 with 0.
  - ROL fills bit 0 with the old C.
  - ROR fills bit 7 with the old C.
  - ASR keeps bit 7.
- R10: SWAP exchanges the two nibbles of `op_a` and leaves the whole status byte unchanged.
- R11: Whenever an operation updates N or V, S equals N XOR V of the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | Destination/first operand |
| op_b | input | 8 | Source operand or immediate |
| op_code | input | 5 | Operation select (R1 encoding) |
| status_in | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| status_out | output | 8 | Next status byte |
| result_we | output | 1 | Result write-back strobe |

## Verification
The checks inside the design assume that `op_code`, `op_a`, `op_b` and `status_in` are stable by the time the outputs are inspected. They also assume every input bit is 0 or 1, because the flag relations only hold on settled, known values.

The bench changes inputs only on the falling clock edge and reads the outputs on the rising edge. It draws opcodes from the whole 5-bit range, so undefined codes are exercised as well. Operands and incoming status bytes are fully random. Directed vectors cover the overflow, borrow and zero-chaining corners.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP   = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC  = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR  = 5'd16, OP_ASR = 5'd17, OP_SWAP = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_NONE, UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT
  } alu_unit_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  localparam logic [7:0] MASK_FULL  = 8'h3F;  // H S V N Z C
  localparam logic [7:0] MASK_CZNVS = 8'h1F;  // S V N Z C
  localparam logic [7:0] MASK_ZNVS  = 8'h1E;  // S V N Z

  function automatic logic [7:0] flag_mask(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_CP, OP_CPC, OP_NEG:            flag_mask = MASK_FULL;
      OP_COM, OP_LSL, OP_LSR, OP_ROL,
      OP_ROR, OP_ASR:                   flag_mask = MASK_CZNVS;
      OP_AND, OP_OR, OP_XOR,
      OP_INC, OP_DEC:                   flag_mask = MASK_ZNVS;
      default:                          flag_mask = 8'h00;
    endcase
  endfunction

  function automatic alu_unit_e unit_of(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
      OP_COM, OP_NEG, OP_INC, OP_DEC:             unit_of = UNIT_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_SWAP:             unit_of = UNIT_LOGIC;
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:     unit_of = UNIT_SHIFT;
      default:                                    unit_of = UNIT_NONE;
    endcase
  endfunction

  function automatic logic writes_result(input alu_op_e op);
    case (op)
      OP_CP, OP_CPC: writes_result = 1'b0;
      default:       writes_result = (unit_of(op) != UNIT_NONE);
    endcase
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HB = W / 2;

  function automatic logic [W:0] full_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci, input logic s);
    logic [W:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{W{1'b0}}, ci};
    full_op = s ? (xe - ye - ce) : (xe + ye + ce);
  endfunction

  function automatic logic [HB:0] low_op(input logic [HB-1:0] x, input logic [HB-1:0] y,
                                         input logic ci, input logic s);
    logic [HB:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{HB{1'b0}}, ci};
    low_op = s ? (xe - ye - ce) : (xe + ye + ce);
  endfunction

  logic [W:0]  wide;
  logic [HB:0] low;

  always_comb begin
    wide  = full_op(a, b, cin, sub);
    low   = low_op(a[HB-1:0], b[HB-1:0], cin, sub);
    sum   = wide[W-1:0];
    c_out = wide[W];
    h_out = low[HB];
    if (sub)
      v_out = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
    else
      v_out = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         z_in,
  output logic [W-1:0] res,
  output logic         c_new,
  output logic         h_new,
  output logic         v_new,
  output logic         z_new
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] x, y, s_sum;
  logic         ci, do_sub, s_c, s_h, s_v, chain_z;

  always_comb begin
    x = a; y = b; ci = 1'b0; do_sub = 1'b0; chain_z = 1'b0;
    case (op)
      OP_ADC:        ci = c_in;
      OP_SUB, OP_CP: do_sub = 1'b1;
      OP_SBC, OP_CPC: begin do_sub = 1'b1; ci = c_in; chain_z = 1'b1; end
      OP_NEG:        begin x = ZERO; y = a; do_sub = 1'b1; end
      OP_INC:        y = ONE;
      OP_DEC:        begin y = ONE; do_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(x), .b(y), .cin(ci), .sub(do_sub),
    .sum(s_sum), .c_out(s_c), .h_out(s_h), .v_out(s_v)
  );

  always_comb begin
    if (op == OP_COM) begin
      res   = ~a;
      c_new = 1'b1;
      h_new = 1'b0;
      v_new = 1'b0;
    end else if (op == OP_NEG) begin
      res   = s_sum;
      c_new = (s_sum != ZERO);
      h_new = s_h;
      v_new = s_v;
    end else begin
      res   = s_sum;
      c_new = s_c;
      h_new = s_h;
      v_new = s_v;
    end
    z_new = (res == ZERO) && (!chain_z || z_in);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int HB = W / 2;

  function automatic logic [W-1:0] nib_swap(input logic [W-1:0] v);
    nib_swap = {v[HB-1:0], v[W-1:HB]};
  endfunction

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SWAP: res = nib_swap(a);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         c_new
);
  logic left, fill;

  always_comb begin
    left = (op == OP_LSL) || (op == OP_ROL);
    case (op)
      OP_ROL, OP_ROR: fill = c_in;
      OP_ASR:         fill = a[W-1];
      default:        fill = 1'b0;
    endcase
    if (left) begin
      res   = {a[W-2:0], fill};
      c_new = a[W-1];
    end else begin
      res   = {fill, a[W-1:1]};
      c_new = a[0];
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [4:0]   op_code,
  input  logic [7:0]   status_in,
  output logic [W-1:0] result,
  output logic [7:0]   status_out,
  output logic         result_we
);
  alu_op_e      op;
  alu_unit_e    unit;
  logic [7:0]   mask;
  logic [7:0]   fresh;
  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_c, ar_h, ar_v, ar_z, sh_c;

  assign op   = alu_op_e'(op_code);
  assign unit = unit_of(op);
  assign mask = flag_mask(op);

  alu8_arith #(.W(W)) u_arith (
    .op(op), .a(op_a), .b(op_b), .c_in(status_in[FL_C]), .z_in(status_in[FL_Z]),
    .res(ar_res), .c_new(ar_c), .h_new(ar_h), .v_new(ar_v), .z_new(ar_z)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .res(lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .op(op), .a(op_a), .c_in(status_in[FL_C]), .res(sh_res), .c_new(sh_c)
  );

  always_comb begin
    fresh  = status_in;
    result = '0;
    case (unit)
      UNIT_ARITH: begin
        result      = ar_res;
        fresh[FL_C] = ar_c;
        fresh[FL_H] = ar_h;
        fresh[FL_V] = ar_v;
        fresh[FL_Z] = ar_z;
      end
      UNIT_LOGIC: begin
        result      = lg_res;
        fresh[FL_V] = 1'b0;
        fresh[FL_Z] = (lg_res == '0);
      end
      UNIT_SHIFT: begin
        result      = sh_res;
        fresh[FL_C] = sh_c;
        fresh[FL_V] = sh_res[W-1] ^ sh_c;
        fresh[FL_Z] = (sh_res == '0);
      end
      default: ;
    endcase
    fresh[FL_N] = result[W-1];
    fresh[FL_S] = fresh[FL_N] ^ fresh[FL_V];
  end

  for (genvar i = 0; i < 8; i++) begin : g_merge
    assign status_out[i] = mask[i] ? fresh[i] : status_in[i];
  end

  assign result_we = writes_result(op);

  // Checks on the settled outputs, beside the merge they guard.
  always_comb begin
    assert_it_kept_R3: assert (status_out[7:6] == status_in[7:6])
      else $error("I/T flag altered");
    if (mask[FL_N] || mask[FL_V])
      assert_sign_rule_R11: assert (status_out[FL_S] == (status_out[FL_N] ^ status_out[FL_V]))
        else $error("S differs from N^V");
    if (op == OP_CP || op == OP_CPC)
      assert_no_write_R4: assert (!result_we) else $error("compare wrote result");
    if (op == OP_SWAP)
      assert_swap_flags_R10: assert (status_out == status_in) else $error("swap changed flags");
    if (unit == UNIT_SHIFT)
      assert_shift_v_R9: assert (status_out[FL_V] == (status_out[FL_N] ^ status_out[FL_C]))
        else $error("shift V rule broken");
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      assert_logic_flags_R6: assert (!status_out[FL_V] &&
                                     status_out[FL_C] == status_in[FL_C] &&
                                     status_out[FL_H] == status_in[FL_H])
        else $error("logic op flag error");
    if ((op == OP_SBC || op == OP_CPC) && !status_in[FL_Z])
      assert_z_chain_R5: assert (!status_out[FL_Z]) else $error("Z chain lost");
    if (unit == UNIT_NONE)
      assert_idle_code_R1: assert (!result_we && status_out == status_in)
        else $error("undefined code had effect");
  end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
  logic       clk = 1'b0;
  logic [7:0] op_a, op_b, status_in, result, status_out;
  logic [4:0] op_code;
  logic       result_we;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alu8_core i_alu8_core (
    .op_a(op_a), .op_b(op_b), .op_code(op_code), .status_in(status_in),
    .result(result), .status_out(status_out), .result_we(result_we)
  );

  // Reference model written with integer arithmetic. Returns {we, result, status}.
  function automatic logic [16:0] model(input int op, input int a, input int b, input logic [7:0] s);
    int r = 0, sr, sa, sb, cin;
    bit we = 1, c = 0, h = 0, v = 0, z, n, zchain = 0;
    logic [7:0] m = 8'h00, nf;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(s[0]) : 0;
        r = a + b + cin; c = (r > 255); h = ((a % 16) + (b % 16) + cin) > 15;
        sr = sa + sb + cin; v = (sr > 127) || (sr < -128); r = r % 256; m = 8'h3F;
      end
      2, 3, 4, 5: begin
        cin = (op == 3 || op == 5) ? int'(s[0]) : 0;
        r = a - b - cin; c = (r < 0); h = ((a % 16) - (b % 16) - cin) < 0;
        sr = sa - sb - cin; v = (sr > 127) || (sr < -128); r = (r + 256) % 256;
        m = 8'h3F; zchain = (op == 3 || op == 5); we = (op < 4);
      end
      6: begin r = a & b; m = 8'h1E; end
      7: begin r = a | b; m = 8'h1E; end
      8: begin r = a ^ b; m = 8'h1E; end
      9: begin r = 255 - a; c = 1; m = 8'h1F; end
      10: begin r = (256 - a) % 256; c = (a != 0); v = (a == 128); h = (a % 16) != 0; m = 8'h3F; end
      11: begin r = (a + 1) % 256; v = (a == 127); m = 8'h1E; end
      12: begin r = (a + 255) % 256; v = (a == 128); m = 8'h1E; end
      13: begin r = (a * 2) % 256; c = (a >= 128); m = 8'h1F; end
      14: begin r = a / 2; c = a % 2; m = 8'h1F; end
      15: begin r = (a * 2) % 256 + int'(s[0]); c = (a >= 128); m = 8'h1F; end
      16: begin r = a / 2 + 128 * int'(s[0]); c = a % 2; m = 8'h1F; end
      17: begin r = a / 2 + (a & 128); c = a % 2; m = 8'h1F; end
      18: begin r = (a % 16) * 16 + a / 16; end
      default: we = 0;
    endcase
    n = (r >= 128);
    z = (r == 0) && (!zchain || s[1]);
    if (op >= 13 && op <= 17) v = n ^ c;
    nf = {2'b00, h, n ^ v, v, n, z, c};
    model = {we, r[7:0], (s & ~m) | (nf & m)};
  endfunction

  task automatic apply(input int op, input int a, input int b, input logic [7:0] s, input string req);
    logic [16:0] exp;
    @(negedge clk);
    op_code = op[4:0]; op_a = a[7:0]; op_b = b[7:0]; status_in = s;
    exp = model(op, a, b, s);
    @(posedge clk);
    vectors++;
    if (result_we !== exp[16] || status_out !== exp[7:0] || (exp[16] && result !== exp[15:8])) begin
      miscompares++;
      $display("FAIL %s op=%0d a=%02h b=%02h s=%02h: got we=%b res=%02h st=%02h, expected we=%b res=%02h st=%02h",
               req, op, a, b, s, result_we, result, status_out, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    int seed;
    op_code = 5'd31; op_a = '0; op_b = '0; status_in = '0;
    seed = $urandom(32'h5EED_0A1C);
    // Idle state: undefined code has no effect (R1), I/T preserved (R3)
    apply(31, 8'h12, 8'h34, 8'hC3, "R1");
    apply(19, 8'hFF, 8'h01, 8'h5A, "R1");
    // Directed corners
    apply(0, 8'h7F, 8'h01, 8'h00, "R2");          // signed overflow, half carry
    apply(0, 8'hFF, 8'h01, 8'hC0, "R2");          // carry out, zero
    apply(1, 8'h0F, 8'h00, 8'h01, "R2");          // carry in into half carry
    apply(2, 8'h80, 8'h01, 8'h00, "R4");          // signed overflow on subtract
    apply(2, 8'h00, 8'h01, 8'h00, "R4");          // borrow
    apply(4, 8'h33, 8'h33, 8'h00, "R4");          // compare equal, no write
    apply(5, 8'h10, 8'h10, 8'h00, "R5");          // equal but prior Z=0 keeps Z clear
    apply(5, 8'h10, 8'h10, 8'h02, "R5");          // equal and prior Z=1
    apply(3, 8'h01, 8'h00, 8'h03, "R5");          // SBC with carry giving zero
    apply(6, 8'hF0, 8'h0F, 8'h29, "R6");          // AND zero, C/H kept, V cleared
    apply(8, 8'h80, 8'h00, 8'h08, "R6");
    apply(9, 8'h00, 8'h00, 8'h00, "R7");          // COM
    apply(10, 8'h80, 8'h00, 8'h00, "R7");         // NEG 0x80 overflow
    apply(10, 8'h00, 8'h00, 8'h21, "R7");         // NEG zero, no carry
    apply(11, 8'h7F, 8'h00, 8'h21, "R8");         // INC overflow, C/H kept
    apply(12, 8'h80, 8'h00, 8'h00, "R8");         // DEC overflow
    apply(17, 8'h81, 8'h00, 8'h00, "R9");         // ASR keeps bit 7
    apply(15, 8'h80, 8'h00, 8'h01, "R9");         // ROL through carry
    apply(16, 8'h01, 8'h00, 8'h01, "R9");         // ROR through carry
    apply(14, 8'h01, 8'h00, 8'h00, "R9");         // LSR to zero
    apply(13, 8'h40, 8'h00, 8'h20, "R9");         // LSL into sign, H kept
    apply(18, 8'hA5, 8'h00, 8'hFF, "R10");        // SWAP flags untouched
    apply(2, 8'h01, 8'h02, 8'h00, "R11");         // S = N ^ V
    // Constrained random sweep over every code
    for (int k = 0; k < 4000; k++) begin
      int op;
      op = int'($urandom % 24);
      if ($urandom % 4 == 0) op = int'($urandom % 32);
      apply(op, int'($urandom % 256), int'($urandom % 256), 8'($urandom), "R1..R11 random");
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule